// File: doc/BRIEF.md
# Channel-Indexed Conversion Result Logger

This block copies every finished conversion from an analog-to-digital converter into a small on-chip result RAM. No software takes part. The RAM is indexed by the number of the channel that was converted. The converter reports which channel it has just finished on a channel-number output, and it raises a one-cycle end-of-conversion pulse. The logger turns that pulse straight into a read request on the converter's register port. The channel number is placed in the low bits of the register address and the upper address bits are held at zero. When the register port answers with its data-ready strobe, that strobe writes the returned word into the RAM.

The RAM write address is the channel number captured when the request is issued. Changes on the channel output while the answer is pending therefore have no effect. Only one request can be outstanding at a time. An end-of-conversion pulse that arrives while a request is still pending is dropped and sets a sticky overrun flag. If no data-ready arrives within a parameterised number of cycles, the request is abandoned and a sticky timeout flag is set. A host reads the stored results through a registered read port with one cycle of latency.

Top module: `chan_result_logger`

## Requirements
- R1: `rp_addr` combinationally equals the channel input zero-extended to the register-port width: bits 4:0 carry `cv_chan` and bits 6:5 are 0.
- R2: `rp_en` is high in exactly those cycles in which `cv_eoc` is high and either no request is outstanding or the outstanding one completes in that same cycle. In every other cycle it is low.
- R3: While a request is outstanding, a cycle with `rp_ready` high writes `rp_data` into RAM entry (latched channel) and ends the request. `rp_ready` with no request outstanding writes nothing.
- R4: The RAM write address is the channel sampled in the cycle the request was issued. Later changes of `cv_chan` before `rp_ready` do not affect it.
- R5: `cv_eoc` while a request is outstanding, with no `rp_ready` in that cycle, issues no request and sets `overrun`. The flag stays high until reset.
- R6: A request is abandoned if `rp_ready` has not arrived within TIMEOUT cycles after its issue cycle. Abandoning sets `timeout_err`, which stays high until reset. A later `rp_ready` writes nothing.
- R7: `host_rd` high with `host_addr` A makes `host_data` show entry A in the next cycle. With `host_rd` low, `host_data` holds its value. A read of the entry being written in the same cycle returns the old contents.
- R8: After reset, `overrun`, `timeout_err` and `host_data` are 0, every RAM entry reads 0, and no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cv_chan | input | 5 | Channel number of the conversion just finished |
| cv_eoc | input | 1 | One-cycle end-of-conversion pulse |
| rp_addr | output | 7 | Register-port read address |
| rp_en | output | 1 | Register-port read enable |
| rp_data | input | 16 | Register-port read data |
| rp_ready | input | 1 | Register-port data-ready strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Host read address (channel) |
| host_data | output | 16 | Host read data, one cycle after `host_rd` |
| overrun | output | 1 | Sticky: an end-of-conversion pulse was dropped |
| timeout_err | output | 1 | Sticky: a request was abandoned without data-ready |

## Verification
The bench builds the block with a 5-bit channel, a 7-bit register address, 16-bit data, TIMEOUT of 6 and the old-data read-during-write variant. The short timeout lets a request expire, and a late strobe be shown to have no effect, within a few cycles. It also allows a strobe to be placed on the very last cycle before expiry. The old-data variant makes a host read that collides with a write return a value that can be told apart from the newly written one.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic [0:0] {
      TRK_IDLE = 1'b0,
      TRK_WAIT = 1'b1
   } trk_state_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/cap_addr_map.sv
module cap_addr_map #(
   parameter int unsigned CHAN_W    = 5,
   parameter int unsigned RP_ADDR_W = 7
) (
   input  logic [CHAN_W-1:0]    chan,
   output logic [RP_ADDR_W-1:0] addr
);

   localparam int unsigned PAD_W = RP_ADDR_W - CHAN_W;

   if (RP_ADDR_W < CHAN_W) begin : g_bad_width
      $error("cap_addr_map: register address narrower than channel");
   end

   if (PAD_W > 0) begin : g_pad
      assign addr = {{PAD_W{1'b0}}, chan};
   end else begin : g_direct
      assign addr = chan;
   end

endmodule

// File: rtl/cap_req_track.sv
module cap_req_track
   import cap_pkg::*;
#(
   parameter int unsigned CHAN_W  = 5,
   parameter int unsigned TIMEOUT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eoc,
   input  logic [CHAN_W-1:0] chan,
   input  logic              rdy,
   output logic              req_fire,
   output logic              wr_en,
   output logic [CHAN_W-1:0] wr_chan,
   output logic              overrun,
   output logic              timeout_err
);

   localparam int unsigned CNT_W = cnt_width(TIMEOUT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   if (TIMEOUT < 1) begin : g_bad_timeout
      $error("cap_req_track: TIMEOUT must be at least 1");
   end

   trk_state_e        st;
   logic [CNT_W-1:0]  wait_cnt;
   logic [CHAN_W-1:0] lat_chan;
   logic              busy;

   assign busy     = (st == TRK_WAIT);
   assign wr_en    = busy && rdy;
   assign req_fire = eoc && (!busy || rdy);
   assign wr_chan  = lat_chan;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= TRK_IDLE;
         wait_cnt <= '0;
         lat_chan <= '0;
      end else if (req_fire) begin
         st       <= TRK_WAIT;
         wait_cnt <= '0;
         lat_chan <= chan;
      end else if (wr_en) begin
         st       <= TRK_IDLE;
      end else if (busy) begin
         if (wait_cnt == LAST) begin
            st <= TRK_IDLE;
         end else begin
            wait_cnt <= wait_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun     <= 1'b0;
         timeout_err <= 1'b0;
      end else begin
         if (eoc && !req_fire) begin
            overrun <= 1'b1;
         end
         if (busy && !rdy && !req_fire && wait_cnt == LAST) begin
            timeout_err <= 1'b1;
         end
      end
   end

   assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eoc) |=> $stable(lat_chan));

   assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   assert_timeout_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> timeout_err);

   assert_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (wait_cnt <= LAST));

   assert_abandon_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rdy && !eoc && wait_cnt == LAST) |=> (!busy && timeout_err));

endmodule

// File: rtl/cap_result_ram.sv
module cap_result_ram #(
   parameter int unsigned AW     = 5,
   parameter int unsigned DW     = 16,
   parameter bit          RD_OLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   if (AW > 10) begin : g_bad_depth
      $error("cap_result_ram: depth too large for register storage");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   if (RD_OLD) begin : g_read_old
      assign rd_next = mem[raddr];
   end else begin : g_read_new
      assign rd_next = (we && (waddr == raddr)) ? wdata : mem[raddr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= rd_next;
      end
   end

   assert_host_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rdata));

endmodule

// File: rtl/chan_result_logger.sv
module chan_result_logger #(
   parameter int unsigned CHAN_W    = 5,
   parameter int unsigned RP_ADDR_W = 7,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned TIMEOUT   = 64,
   parameter bit          RD_OLD    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CHAN_W-1:0]    cv_chan,
   input  logic                 cv_eoc,
   output logic [RP_ADDR_W-1:0] rp_addr,
   output logic                 rp_en,
   input  logic [DATA_W-1:0]    rp_data,
   input  logic                 rp_ready,
   input  logic                 host_rd,
   input  logic [CHAN_W-1:0]    host_addr,
   output logic [DATA_W-1:0]    host_data,
   output logic                 overrun,
   output logic                 timeout_err
);

   logic              wr_en;
   logic [CHAN_W-1:0] wr_chan;

   cap_addr_map #(
      .CHAN_W    (CHAN_W),
      .RP_ADDR_W (RP_ADDR_W)
   ) u_addr_map (
      .chan (cv_chan),
      .addr (rp_addr)
   );

   cap_req_track #(
      .CHAN_W  (CHAN_W),
      .TIMEOUT (TIMEOUT)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .eoc         (cv_eoc),
      .chan        (cv_chan),
      .rdy         (rp_ready),
      .req_fire    (rp_en),
      .wr_en       (wr_en),
      .wr_chan     (wr_chan),
      .overrun     (overrun),
      .timeout_err (timeout_err)
   );

   cap_result_ram #(
      .AW     (CHAN_W),
      .DW     (DATA_W),
      .RD_OLD (RD_OLD)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_chan),
      .wdata (rp_data),
      .re    (host_rd),
      .raddr (host_addr),
      .rdata (host_data)
   );

   assert_req_needs_eoc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rp_en |-> cv_eoc);

   assert_write_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> rp_ready);

endmodule

// File: tb/chan_result_logger_bench.sv
module chan_result_logger_bench;

   localparam int TMO = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  cv_chan = '0;
   logic        cv_eoc = 1'b0;
   logic [6:0]  rp_addr;
   logic        rp_en;
   logic [15:0] rp_data = '0;
   logic        rp_ready = 1'b0;
   logic        host_rd = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [15:0] host_data;
   logic        overrun;
   logic        timeout_err;

   int errs = 0;
   int checks = 0;
   string cur_tag = "R7";

   // reference model state
   logic [15:0] m_mem [32];
   bit          m_pend = 0;
   int          m_cnt = 0;
   logic [4:0]  m_ch = '0;
   logic [15:0] m_hdata = '0;
   bit          m_ovr = 0;
   bit          m_tmo = 0;

   always #2 clk = ~clk;

   chan_result_logger #(
      .CHAN_W (5), .RP_ADDR_W (7), .DATA_W (16), .TIMEOUT (TMO), .RD_OLD (1'b1)
   ) u_chan_result_logger (
      .clk (clk), .rst_n (rst_n), .cv_chan (cv_chan), .cv_eoc (cv_eoc),
      .rp_addr (rp_addr), .rp_en (rp_en), .rp_data (rp_data), .rp_ready (rp_ready),
      .host_rd (host_rd), .host_addr (host_addr), .host_data (host_data),
      .overrun (overrun), .timeout_err (timeout_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // drive one cycle at the falling edge, compare, advance model and clock
   task automatic cyc(input bit e, input logic [4:0] ch, input bit r,
                      input logic [15:0] d, input bit hr, input logic [4:0] ha);
      bit acc;
      cv_eoc = e; cv_chan = ch; rp_ready = r; rp_data = d;
      host_rd = hr; host_addr = ha;
      #1;
      acc = e && (!m_pend || r);
      chk("R2 rp_en", {31'b0, rp_en}, {31'b0, acc});
      chk("R1 rp_addr", {25'b0, rp_addr}, {27'b0, ch});
      chk({cur_tag, " host_data"}, {16'b0, host_data}, {16'b0, m_hdata});
      chk("R5 overrun", {31'b0, overrun}, {31'b0, m_ovr});
      chk("R6 timeout_err", {31'b0, timeout_err}, {31'b0, m_tmo});
      if (hr) m_hdata = m_mem[ha];
      if (m_pend && r) m_mem[m_ch] = d;
      if (e && !acc) m_ovr = 1;
      if (acc) begin
         m_pend = 1; m_cnt = 0; m_ch = ch;
      end else if (m_pend && r) begin
         m_pend = 0;
      end else if (m_pend) begin
         if (m_cnt == TMO - 1) begin m_pend = 0; m_tmo = 1; end
         else m_cnt++;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 5'd0, 0, 16'h0, 0, 5'd0);
   endtask

   task automatic rd(input logic [4:0] a);
      cyc(0, 5'd0, 0, 16'h0, 1, a);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state, including RAM contents at both ends
      cur_tag = "R8";
      idle(1);
      rd(5'd0); rd(5'd31); rd(5'd17); idle(1);

      // R3: plain capture, ready two cycles after the request
      cur_tag = "R3";
      cyc(1, 5'd3, 0, 16'h0, 0, 5'd0);
      idle(1);
      cyc(0, 5'd0, 1, 16'hA5A5, 0, 5'd0);
      rd(5'd3); idle(1);
      // R3: ready with nothing outstanding is ignored
      cyc(0, 5'd9, 1, 16'hDEAD, 0, 5'd0);
      rd(5'd9); rd(5'd0); idle(1);

      // R4: channel output changes while waiting
      cur_tag = "R4";
      cyc(1, 5'd31, 0, 16'h0, 0, 5'd0);
      cyc(0, 5'd7, 0, 16'h0, 0, 5'd0);
      cyc(0, 5'd12, 1, 16'h1234, 0, 5'd0);
      rd(5'd31); rd(5'd7); rd(5'd12); idle(1);

      // R2: new request in the same cycle the previous completes
      cur_tag = "R2";
      cyc(1, 5'd4, 0, 16'h0, 0, 5'd0);
      cyc(1, 5'd5, 1, 16'h4444, 0, 5'd0);
      cyc(0, 5'd0, 1, 16'h5555, 0, 5'd0);
      rd(5'd4); rd(5'd5); idle(1);

      // R5: second pulse while outstanding is dropped
      cur_tag = "R5";
      cyc(1, 5'd10, 0, 16'h0, 0, 5'd0);
      cyc(1, 5'd11, 0, 16'h0, 0, 5'd0);
      cyc(0, 5'd0, 1, 16'h0A0A, 0, 5'd0);
      rd(5'd10); rd(5'd11); idle(2);

      // R6: ready on the last allowed cycle still writes
      cur_tag = "R6";
      cyc(1, 5'd20, 0, 16'h0, 0, 5'd0);
      idle(TMO - 1);
      cyc(0, 5'd0, 1, 16'h2020, 0, 5'd0);
      rd(5'd20); idle(1);
      // R6: no ready in time -> abandoned, late ready ignored
      cyc(1, 5'd21, 0, 16'h0, 0, 5'd0);
      idle(TMO);
      cyc(0, 5'd0, 1, 16'h2121, 0, 5'd0);
      rd(5'd21); idle(2);

      // R7: read colliding with a write returns old data, then new
      cur_tag = "R7";
      cyc(1, 5'd3, 0, 16'h0, 0, 5'd0);
      cyc(0, 5'd0, 1, 16'h3333, 1, 5'd3);
      idle(2);
      rd(5'd3);
      idle(3);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #20000;
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule